// File: doc/BRIEF.md
# Masked Channel Change Event Detector

The block watches a bank of binary channel levels delivered as periodic samples. Each accepted sample is compared bit by bit against the levels recorded from the sample before. Every enabled channel whose level differs yields one event on a valid/ready stream. The event gives the channel index and whether the level went up or down. When one sample changes several channels, the events leave one at a time, lowest index first. While any of them is still waiting, the sample input is held off.

Per-channel enable and disable pulses can be applied at any time. Turning a channel on never produces an event of its own. The recorded level always follows the most recent accepted sample, whether or not the channel is enabled. A pulse that lands in the same cycle as an accepted sample takes that sample's bit as the reference for the channel.

Top module: `chg_evt_detect`

## Requirements
- R1: When a sample is accepted, an event is produced for each channel that is enabled and whose new bit differs from its recorded bit.
- R2: The evt_rise output is 1 when the channel's new bit is 1, and 0 when the new bit is 0.
- R3: A disabled channel produces no event. Its recorded bit is still replaced by every accepted sample, so enabling it later raises no event for changes made while it was off.
- R4: A channel given an enable or disable pulse in the cycle a sample is accepted takes that sample's bit as its reference and raises no event for that sample. A disable pulse wins over an enable pulse given in the same cycle.
- R5: Events from one sample are emitted in ascending channel index order.
- R6: An accepted sample with no enabled change produces no event. After every accepted sample, the recorded state equals that sample.
- R7: After reset all channels are enabled, every recorded bit is 0, evt_valid is 0 and smp_ready is 1.
- R8: smp_ready is 0 while any event is pending. A sample is taken only in a cycle where smp_valid and smp_ready are both 1. A strobe offered while the block is stalled has no effect.
- R9: While evt_valid is 1 and evt_ready is 0, evt_chan and evt_rise hold their values.
- R10: A disable pulse does not cancel events already queued from an earlier sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | A new sample is offered |
| smp_data | input | NCH | Channel levels of the offered sample |
| smp_ready | output | 1 | Block can take a sample |
| en_set | input | NCH | Per-channel enable pulse |
| en_clr | input | NCH | Per-channel disable pulse |
| evt_valid | output | 1 | An event is presented |
| evt_ready | input | 1 | Consumer takes the event |
| evt_chan | output | IW | Index of the changed channel |
| evt_rise | output | 1 | 1 for a rising change, 0 for a falling one |

## Verification
The bench builds the block with its default NCH of 32, so IW is 5. This lets the all-channels case queue 32 events behind one sample and takes the encoder through its highest index, 31. Random samples with sparse toggles are mixed with random enable and disable pulses, some of them in the sample's own cycle. Consumer back-pressure and stalled sample strobes are also random, so ordering, holding and same-cycle reference capture are all tried across the whole index range.

// File: rtl/ced_pkg.sv
// Shared constants and helpers for the change event detector.
package ced_pkg;
    localparam int CED_NCH_DEF = 32;

    // Width of a channel index for n channels (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/ced_lsb_enc.sv
// Finds the lowest set bit of a vector.
// Assumes nothing about the vector; idx is 0 when no bit is set.
module ced_lsb_enc #(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input  logic [W-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Reduction for the presence flag.
    assign any = |vec;

    // Scan from the top so the lowest set bit is assigned last.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/ced_track.sv
// Holds the recorded level and enable flag of each channel, and forms
// the enabled-change vector for the sample on the input.
// Assumes take is high only in a cycle where the sample is accepted.
module ced_track #(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           take,
    input  logic [NCH-1:0] smp_data,
    input  logic [NCH-1:0] en_set,
    input  logic [NCH-1:0] en_clr,
    output logic [NCH-1:0] chg_vec,
    output logic [NCH-1:0] ref_q,
    output logic [NCH-1:0] mask_q
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        // Recorded level follows every accepted sample.
        always_ff @(posedge clk) begin
            if (!rst_n)    ref_q[g] <= 1'b0;
            else if (take) ref_q[g] <= smp_data[g];
        end

        // Enable flag: disable wins over enable.
        always_ff @(posedge clk) begin
            if (!rst_n)         mask_q[g] <= 1'b1;
            else if (en_clr[g]) mask_q[g] <= 1'b0;
            else if (en_set[g]) mask_q[g] <= 1'b1;
        end

        // A pulsed channel re-references on this sample, so it is excluded.
        assign chg_vec[g] = (smp_data[g] ^ ref_q[g]) & mask_q[g]
                            & ~en_set[g] & ~en_clr[g];
    end
endmodule

// File: rtl/ced_drain.sv
// Keeps the pending change set of the last accepted sample and presents
// it as events, lowest channel first, one per accepted handshake.
// Assumes take is only high while nothing is pending.
module ced_drain #(
    parameter int NCH = 32,
    parameter int IW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           take,
    input  logic [NCH-1:0] chg_vec,
    input  logic [NCH-1:0] smp_data,
    input  logic           evt_ready,
    output logic           evt_valid,
    output logic [IW-1:0]  evt_chan,
    output logic           evt_rise
);
    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] lvl_q;

    ced_lsb_enc #(.W(NCH), .IW(IW)) u_enc (
        .vec (pend_q),
        .any (evt_valid),
        .idx (evt_chan)
    );

    // Pending set: loaded on a sample, lowest bit dropped per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pend_q <= '0;
        else if (take)                   pend_q <= chg_vec;
        else if (evt_valid && evt_ready) pend_q <= pend_q & (pend_q - 1'b1);
    end

    // Copy of the sample the pending events belong to.
    always_ff @(posedge clk) begin
        if (!rst_n)    lvl_q <= '0;
        else if (take) lvl_q <= smp_data;
    end

    // Direction is the new level of the presented channel.
    assign evt_rise = lvl_q[evt_chan];
endmodule

// File: rtl/chg_evt_detect.sv
// Top: compares each accepted sample with the recorded channel levels and
// streams one event per enabled changed channel, in ascending order.
// Assumes the consumer obeys valid/ready; samples wait while events drain.
module chg_evt_detect #(
    parameter int NCH = ced_pkg::CED_NCH_DEF,
    parameter int IW  = ced_pkg::idx_width(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           smp_valid,
    input  logic [NCH-1:0] smp_data,
    output logic           smp_ready,
    input  logic [NCH-1:0] en_set,
    input  logic [NCH-1:0] en_clr,
    output logic           evt_valid,
    input  logic           evt_ready,
    output logic [IW-1:0]  evt_chan,
    output logic           evt_rise
);
    logic           take;
    logic [NCH-1:0] chg_vec;
    logic [NCH-1:0] ref_q;
    logic [NCH-1:0] mask_q;

    // Samples are stalled while any event is still queued.
    assign smp_ready = ~evt_valid;
    assign take      = smp_valid & smp_ready;

    ced_track #(.NCH(NCH)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .smp_data (smp_data),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .chg_vec  (chg_vec),
        .ref_q    (ref_q),
        .mask_q   (mask_q)
    );

    ced_drain #(.NCH(NCH), .IW(IW)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .chg_vec   (chg_vec),
        .smp_data  (smp_data),
        .evt_ready (evt_ready),
        .evt_valid (evt_valid),
        .evt_chan  (evt_chan),
        .evt_rise  (evt_rise)
    );
endmodule

// File: rtl/ced_chk.sv
// Protocol and ordering checks for chg_evt_detect, bound to every instance.
module ced_chk #(
    parameter int NCH = 32,
    parameter int IW  = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           smp_valid,
    input logic           smp_ready,
    input logic [NCH-1:0] smp_data,
    input logic           evt_valid,
    input logic           evt_ready,
    input logic [IW-1:0]  evt_chan,
    input logic           evt_rise,
    input logic [NCH-1:0] ref_q,
    input logic [NCH-1:0] mask_q
);
    // R1/R6: a sample with no enabled difference leaves nothing queued.
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_ready && (((smp_data ^ ref_q) & mask_q) == '0))
        |=> !evt_valid);

    // R2: the direction matches the recorded level of the channel.
    a_r2_dir: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_rise == ref_q[evt_chan]));

    // R5: the next event of the same batch has a higher index.
    a_r5_order: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready) |=> (!evt_valid || (evt_chan > $past(evt_chan))));

    // R9: a presented event holds until taken.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_chan) && $stable(evt_rise)));

    // R8: a strobe offered while events are pending changes no state.
    a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && evt_valid) |=> $stable(ref_q));
endmodule

bind chg_evt_detect ced_chk #(.NCH(NCH), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_data  (smp_data),
    .evt_valid (evt_valid),
    .evt_ready (evt_ready),
    .evt_chan  (evt_chan),
    .evt_rise  (evt_rise),
    .ref_q     (ref_q),
    .mask_q    (mask_q)
);

// File: tb/sim_chg_evt_detect.sv
module sim_chg_evt_detect;
    localparam int NCH = 32;
    localparam int IW  = 5;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           smp_valid = 1'b0;
    logic [NCH-1:0] smp_data = '0;
    logic           smp_ready;
    logic [NCH-1:0] en_set = '0;
    logic [NCH-1:0] en_clr = '0;
    logic           evt_valid;
    logic           evt_ready = 1'b0;
    logic [IW-1:0]  evt_chan;
    logic           evt_rise;

    int n_chk = 0;
    int n_bad = 0;

    logic [NCH-1:0] ref_m;
    logic [NCH-1:0] mask_m;
    int             q_ch[$];
    bit             q_rise[$];

    always #10 clk = ~clk;

    chg_evt_detect #(.NCH(NCH), .IW(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_ready(smp_ready), .en_set(en_set), .en_clr(en_clr),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_chan(evt_chan),
        .evt_rise(evt_rise)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected events of one sample, from the requirements (R1..R4).
    function automatic void predict(input logic [NCH-1:0] d, input logic [NCH-1:0] s,
                                    input logic [NCH-1:0] c);
        for (int i = 0; i < NCH; i++) begin
            if ((d[i] != ref_m[i]) && mask_m[i] && !s[i] && !c[i]) begin
                q_ch.push_back(i);
                q_rise.push_back(d[i]);
            end
        end
    endfunction

    // One cycle of stimulus, starting and ending at a falling edge.
    task automatic apply(input bit v, input logic [NCH-1:0] d,
                         input logic [NCH-1:0] s, input logic [NCH-1:0] c);
        if (v) begin
            check(smp_ready == 1'b1, "R8 ready before sample", 32'(smp_ready), 1);
            predict(d, s, c);
            ref_m = d;
        end
        mask_m = (mask_m | s) & ~c;
        smp_valid = v; smp_data = d; en_set = s; en_clr = c;
        @(negedge clk);
        smp_valid = 1'b0; en_set = '0; en_clr = '0;
    endtask

    // Take every expected event with random back-pressure, then check idle.
    task automatic drain(input bit inject, input logic [NCH-1:0] clr_mid);
        bit first = 1'b1;
        while (q_ch.size() > 0) begin
            int ec = q_ch.pop_front();
            bit er = q_rise.pop_front();
            check(evt_valid == 1'b1, "R1 event present", 32'(evt_valid), 1);
            check(evt_chan == IW'(ec), "R5 channel order", 32'(evt_chan), 32'(ec));
            check(evt_rise == er, "R2 direction", 32'(evt_rise), 32'(er));
            check(smp_ready == 1'b0, "R8 stalled", 32'(smp_ready), 0);
            if (first && inject) begin
                smp_valid = 1'b1; smp_data = ~ref_m;
                @(negedge clk);
                smp_valid = 1'b0;
                check(evt_chan == IW'(ec), "R8 strobe ignored", 32'(evt_chan), 32'(ec));
            end
            if (first && (clr_mid != '0)) begin
                en_clr = clr_mid;
                mask_m = mask_m & ~clr_mid;
                @(negedge clk);
                en_clr = '0;
            end
            first = 1'b0;
            repeat ($urandom_range(0, 2)) begin
                @(negedge clk);
                check(evt_valid && evt_chan == IW'(ec) && evt_rise == er, "R9 hold",
                      32'(evt_chan), 32'(ec));
            end
            evt_ready = 1'b1;
            @(negedge clk);
            evt_ready = 1'b0;
        end
        check(evt_valid == 1'b0, "R6 no extra event", 32'(evt_valid), 0);
        check(smp_ready == 1'b1, "R8 ready after drain", 32'(smp_ready), 1);
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'd2024);
        ref_m = '0;
        mask_m = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state.
        check(evt_valid == 1'b0, "R7 no event after reset", 32'(evt_valid), 0);
        check(smp_ready == 1'b1, "R7 ready after reset", 32'(smp_ready), 1);
        // R7/R1/R5: all channels enabled, all rising from zero.
        apply(1, '1, '0, '0);
        drain(1'b1, '0);
        // R6: unchanged sample.
        apply(1, '1, '0, '0);
        drain(1'b0, '0);
        // R2: all falling.
        apply(1, '0, '0, '0);
        drain(1'b0, '0);
        // R3: low half disabled; toggles there raise nothing.
        apply(0, '0, '0, 32'h0000_FFFF);
        apply(1, 32'hA5A5_A5A5, '0, '0);
        drain(1'b0, '0);
        apply(0, '0, 32'h0000_FFFF, '0);
        apply(1, 32'hA5A5_A5A5, '0, '0);
        drain(1'b0, '0);
        // R4: pulses in the sample cycle re-reference; clear wins over set.
        apply(1, 32'h5A5A_5A5A, 32'h0000_00FF, 32'h0000_FF01);
        drain(1'b0, '0);
        apply(0, '0, 32'h0000_FF01, '0);
        // R10: disable while events are queued keeps them.
        apply(1, 32'h0F0F_0F0F, '0, '0);
        drain(1'b0, '1);
        apply(1, 32'hFFFF_0000, '0, '0);
        drain(1'b0, '0);
        apply(0, '0, '1, '0);
        // Random mix of samples, pulses and stalls.
        for (int k = 0; k < 300; k++) begin
            logic [NCH-1:0] tog = $urandom() & $urandom() & $urandom();
            logic [NCH-1:0] s = ($urandom_range(0, 3) == 0) ? ($urandom() & $urandom()) : '0;
            logic [NCH-1:0] c = ($urandom_range(0, 3) == 0) ? ($urandom() & $urandom() & $urandom()) : '0;
            apply(1, ref_m ^ tog, s, c);
            drain($urandom_range(0, 4) == 0, '0);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule